// File: doc/BRIEF.md
# Thermometer-Code Seven-Segment Digit Decoder

This block turns the level lines of a six-step comparator ladder into one decimal digit from 0 to 6 on a common-anode seven-segment display. The comparators pull their lines low in a fixed order, starting from the first line. The digit shown is the number of lines that are low. The block is purely combinational and has no clock. Its outputs follow its inputs directly.

A static mode input chooses what appears when no line is low. One setting shows the digit 0 and the other turns the display dark. Only seven of the 64 input codes can occur on a healthy ladder. The block flags every other code and blanks the display for it.

Internally the segments come from a reduced form built only from XOR terms. That form relies on the 57 unreachable codes being don't-cares. A plain lookup path computes the same pattern from the decoded digit. It serves as an in-design cross-check, and a parameter can also select it as the driving path.

Top module: `thermo7_seg_decoder`

## Requirements
- R1: Input bit `lvl_n[i]` carries line i+1. A valid code has exactly its k lowest bits at 0 and all others at 1, for k from 0 to 6. The digit shown is k.
- R2: `seg_n[6]` drives segment A and the bits run down to `seg_n[0]`, which drives G. A 0 lights a segment. Digits 1 to 5 show 1001111, 0010010, 0000110, 1001100 and 0100100, written A first.
- R3: Digit 6 (all lines low) shows 0100000, with the top segment A lit.
- R4: With `blank_mode` = 0 and all lines high, the output is 0000001 (digit 0).
- R5: With `blank_mode` = 1 and all lines high, every segment is off (1111111) and `bad_code` is 0.
- R6: Any code that is not one of the seven valid codes sets `bad_code` to 1 and drives all segments to 1, in either mode.
- R7: For each of the seven valid codes `bad_code` is 0.
- R8: For every valid code in both modes, the reduced XOR path and the lookup path produce the same pattern.
- R9: For digits 1 to 6 the pattern does not depend on `blank_mode`.
- R10: The block has no storage. A change on `blank_mode` alone, with no clock, appears at `seg_n` at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lvl_n | input | 6 | Active-low comparator level lines; bit 0 is the first line to go low |
| blank_mode | input | 1 | 1: dark display when no line is low; 0: show digit 0 |
| seg_n | output | 7 | Active-low segment drives, bit 6 = A down to bit 0 = G |
| bad_code | output | 1 | High when the level lines hold a code a thermometer ladder cannot produce |

## Verification
The hardest case to reach is a disagreement between the two decode paths. The reduced equations are only defined on the seven valid codes. A fault in them is hidden whenever the illegal-code blanking overrides the output. To reach it, the stimulus walks all 64 codes in both modes, so every valid code appears under each mode setting. The all-high code is then revisited while the mode flips between clock edges. This is the only code where the two XOR equation sets differ in visible result.

// File: rtl/thermo7_pkg.sv
package thermo7_pkg;

   localparam int unsigned LINES    = 6;
   localparam int unsigned SEGS     = 7;
   localparam int unsigned DIGIT_W  = $clog2(LINES + 1);

   typedef logic [SEGS-1:0]    seg_t;
   typedef logic [LINES-1:0]   lvl_t;
   typedef logic [DIGIT_W-1:0] digit_t;

   localparam seg_t SEG_DARK = '1;

   // Active-low pattern for a digit, segment A in the top bit.
   function automatic seg_t digit_pattern(input digit_t d, input logic dark_zero);
      seg_t p;
      unique case (d)
         3'd0:    p = dark_zero ? SEG_DARK : 7'b000_0001;
         3'd1:    p = 7'b100_1111;
         3'd2:    p = 7'b001_0010;
         3'd3:    p = 7'b000_0110;
         3'd4:    p = 7'b100_1100;
         3'd5:    p = 7'b010_0100;
         3'd6:    p = 7'b010_0000;
         default: p = SEG_DARK;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/thermo7_validate.sv
module thermo7_validate
   import thermo7_pkg::*;
#(
   parameter int unsigned N_LINES = LINES,
   localparam int unsigned CNT_W  = $clog2(N_LINES + 1)
) (
   input  logic [N_LINES-1:0] lvl_n,
   output logic               code_ok,
   output logic [CNT_W-1:0]   level
);

   logic [N_LINES:0] hit;

   // One comparator per legal code: k low bits cleared.
   for (genvar k = 0; k <= N_LINES; k++) begin : g_match
      localparam logic [N_LINES-1:0] PAT = {N_LINES{1'b1}} << k;
      assign hit[k] = (lvl_n == PAT);
   end

   always_comb begin
      level = '0;
      for (int k = 0; k <= N_LINES; k++) begin
         if (hit[k]) level = level | CNT_W'(k);
      end
   end

   assign code_ok = |hit;

   always_comb begin
      // R1
      level_count_chk: assert (!code_ok || ($countones(~lvl_n) == int'(level)))
         else $error("level disagrees with number of low lines");
      // R1
      one_match_chk: assert ($onehot0(hit))
         else $error("more than one legal code matched");
   end

endmodule

// File: rtl/thermo7_xor_dec.sv
module thermo7_xor_dec
   import thermo7_pkg::*;
(
   input  lvl_t lvl_n,
   input  logic dark_zero,
   output seg_t seg_n
);

   logic l1, l2, l3, l4, l5, l6;
   assign {l6, l5, l4, l3, l2, l1} = lvl_n;

   seg_t show_set, dark_set;
   logic mid23;

   // Equation set that shows a 0 for the all-high code.
   always_comb begin
      show_set[6] = l1 ^ l2 ^ l4 ^ l5;
      show_set[5] = ~l5;
      show_set[4] = l2 ^ l3;
      show_set[3] = show_set[6];
      show_set[2] = l1 ^ l2 ^ l3 ^ l6;
      show_set[1] = l1 ^ l4;
      show_set[0] = l2;
   end

   // Equation set that darkens the all-high code; C and E share one term.
   assign mid23 = l2 ^ l3;

   always_comb begin
      dark_set[6] = l2 ^ l4 ^ l5;
      dark_set[5] = ~(l1 ^ l5);
      dark_set[4] = l1 ^ mid23;
      dark_set[3] = dark_set[6];
      dark_set[2] = mid23 ^ l6;
      dark_set[1] = l4;
      dark_set[0] = l2;
   end

   assign seg_n = dark_zero ? dark_set : show_set;

   always_comb begin
      // R2
      ad_tie_chk: assert (seg_n[6] == seg_n[3])
         else $error("segments A and D diverged");
   end

endmodule

// File: rtl/thermo7_lut_dec.sv
module thermo7_lut_dec
   import thermo7_pkg::*;
(
   input  digit_t digit,
   input  logic   dark_zero,
   output seg_t   seg_n
);

   assign seg_n = digit_pattern(digit, dark_zero);

   always_comb begin
      // R3
      six_tail_chk: assert (digit != 3'd6 || seg_n[6] == 1'b0)
         else $error("digit six lost its top segment");
   end

endmodule

// File: rtl/thermo7_seg_decoder.sv
module thermo7_seg_decoder
   import thermo7_pkg::*;
#(
   parameter int unsigned N_LINES     = 6,
   parameter int unsigned N_SEGS      = 7,
   parameter bit          USE_REDUCED = 1'b1,
   parameter bit          OUT_LOW     = 1'b1
) (
   input  logic [N_LINES-1:0] lvl_n,
   input  logic               blank_mode,
   output logic [N_SEGS-1:0]  seg_n,
   output logic               bad_code
);

   if (N_LINES != LINES) begin : g_bad_lines
      $error("reduced equations are fixed to six level lines");
   end
   if (N_SEGS != SEGS) begin : g_bad_segs
      $error("display must have seven segments");
   end

   logic   code_ok;
   digit_t digit;
   seg_t   xor_seg, lut_seg, pick_seg, gated_seg;

   thermo7_validate #(.N_LINES(N_LINES)) u_val (
      .lvl_n   (lvl_n),
      .code_ok (code_ok),
      .level   (digit)
   );

   thermo7_xor_dec u_xor (
      .lvl_n     (lvl_n),
      .dark_zero (blank_mode),
      .seg_n     (xor_seg)
   );

   thermo7_lut_dec u_lut (
      .digit     (digit),
      .dark_zero (blank_mode),
      .seg_n     (lut_seg)
   );

   if (USE_REDUCED) begin : g_reduced
      assign pick_seg = xor_seg;
   end else begin : g_table
      assign pick_seg = lut_seg;
   end

   assign gated_seg = code_ok ? pick_seg : SEG_DARK;
   assign bad_code  = ~code_ok;

   if (OUT_LOW) begin : g_low
      assign seg_n = gated_seg;
   end else begin : g_high
      assign seg_n = ~gated_seg;
   end

   always_comb begin
      // R8
      path_agree_chk: assert (!code_ok || xor_seg == lut_seg)
         else $error("reduced and lookup decode disagree");
      // R6
      bad_dark_chk: assert (code_ok || gated_seg == SEG_DARK)
         else $error("illegal code not blanked");
      // R5
      idle_dark_chk: assert (!(blank_mode && lvl_n == '1) || gated_seg == SEG_DARK)
         else $error("idle code lit a segment in dark mode");
   end

endmodule

// File: tb/thermo7_seg_decoder_tb_top.sv
module thermo7_seg_decoder_tb_top;

   logic       clk = 1'b0;
   logic [5:0] lvl_n;
   logic       blank_mode;
   logic [6:0] seg_n;
   logic       bad_code;
   int         checks = 0;
   int         errors = 0;
   int         cyc    = 0;
   bit         done   = 1'b0;

   always #10 clk = ~clk;

   thermo7_seg_decoder dut_i (
      .lvl_n      (lvl_n),
      .blank_mode (blank_mode),
      .seg_n      (seg_n),
      .bad_code   (bad_code)
   );

   // code, pattern (A..G, active low) with the show-zero setting
   typedef struct packed { logic [5:0] code; logic [6:0] pat; } vec_t;
   localparam vec_t VEC [7] = '{
      '{6'b111111, 7'b0000001},
      '{6'b111110, 7'b1001111},
      '{6'b111100, 7'b0010010},
      '{6'b111000, 7'b0000110},
      '{6'b110000, 7'b1001100},
      '{6'b100000, 7'b0100100},
      '{6'b000000, 7'b0100000}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s code=%b mode=%0b actual=%b expected=%b", req, lvl_n, blank_mode, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      lvl_n = '1;
      blank_mode = 1'b1;
      @(negedge clk);
      // R5: start state, dark mode, idle ladder
      chk("R5", {bad_code, seg_n}, {1'b0, 7'b1111111});

      // sweep every code in both modes: R1 R2 R6 R7 R8 R9
      for (int m = 0; m < 2; m++) begin
         for (int c = 0; c < 64; c++) begin
            logic [7:0] exp;
            @(posedge clk);
            lvl_n = 6'(c);
            blank_mode = m[0];
            exp = {1'b1, 7'b1111111};
            for (int v = 0; v < 7; v++) begin
               if (VEC[v].code == 6'(c)) begin
                  exp = {1'b0, VEC[v].pat};
                  if (v == 0 && m == 1) exp[6:0] = 7'b1111111;
               end
            end
            @(negedge clk);
            chk(exp[7] ? "R6" : "R2_R7_R8", {bad_code, seg_n}, exp);
         end
      end

      // R3: digit six with its tail, both modes
      for (int m = 0; m < 2; m++) begin
         @(posedge clk);
         lvl_n = 6'b000000;
         blank_mode = m[0];
         @(negedge clk);
         chk("R3", {bad_code, seg_n}, {1'b0, 7'b0100000});
      end

      // R4: show-zero mode on idle ladder
      @(posedge clk);
      lvl_n = '1;
      blank_mode = 1'b0;
      @(negedge clk);
      chk("R4", {bad_code, seg_n}, {1'b0, 7'b0000001});

      // R10: flip mode mid-cycle, no clock edge in between
      #3 blank_mode = 1'b1;
      #1 chk("R10", {bad_code, seg_n}, {1'b0, 7'b1111111});
      #1 blank_mode = 1'b0;
      #1 chk("R10", {bad_code, seg_n}, {1'b0, 7'b0000001});

      // R9: digit 4 unaffected by mode flip
      lvl_n = 6'b110000;
      #1 chk("R9", {bad_code, seg_n}, {1'b0, 7'b1001100});
      blank_mode = 1'b1;
      #1 chk("R9", {bad_code, seg_n}, {1'b0, 7'b1001100});

      // R6: a gap in the ladder, both modes
      lvl_n = 6'b111101;
      #1 chk("R6", {bad_code, seg_n}, {1'b1, 7'b1111111});
      blank_mode = 1'b0;
      #1 chk("R6", {bad_code, seg_n}, {1'b1, 7'b1111111});

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule